// File: doc/BRIEF.md
# Reconfigurable Radix-2/4 Pipeline Entry Stage

This block is the entry stage of one data path in a multipath delay-commutator FFT/IFFT pipeline. It accepts one complex fixed-point sample per valid cycle. It deals each run of sixteen valid samples into four quarters of four samples each, called A, B, C and D. A chain of delay segments holds back the first three quarters so that one sample from each quarter reaches a shared butterfly in the same cycle. The first three quarters take twelve cycles to fill. During the last four cycles of the run the butterfly produces one result set per cycle.

A size bit chooses how the butterfly is used. For the 256-point transform (bit low) it computes one radix-4 kernel. For the 128-point transform (bit high) it computes two radix-2 kernels. A commutator then places the four results onto the output lanes using a routing mode, which is the butterfly's position in its four-cycle burst. The inverse transform is formed by conjugating the data around the forward transform.

The size bit and the inverse bit are latched only on a frame-start pulse. Twiddle multiplication and the later stages belong to other blocks.

Top module: `r24_first_stage`

## Requirements
- R1: While reset is held and just after it is released, out_valid is 0, every output lane is 0 and out_mode is 0.
- R2: Before the first in_frame pulse after reset, out_valid stays 0 whatever arrives on in_valid.
- R3: Number the valid samples since frame start n = 0..15, repeating every sixteen. A valid sample whose n is 0 to 11 gives no output. The sample with n = 12+i (i = 0..3) makes, one clock edge later, out_valid = 1 with a = x[i], b = x[4+i], c = x[8+i] and d = x[12+i] of that run.
- R4: With the latched size bit at 0 and forward direction, lane 0 carries a+b+c+d, lane 1 carries a−jb−c+jd, lane 2 carries a−b+c−d and lane 3 carries a+jb−c−jd. Lane k is bits [18k+17:18k] of out_re and of out_im.
- R5: With the latched size bit at 1, the butterfly pairs A with C and B with D. Before commutation its results are, in order, a+c, a−c, b+d and b−d.
- R6: out_mode equals i, the burst position. In 128-point mode, lane k carries pre-commutation result (k+i) mod 4. In 256-point mode the lanes are not rotated.
- R7: With the latched inverse bit at 1, each output equals the conjugate of the forward result of the conjugated inputs. In radix-4 this swaps the lane-1 and lane-3 formulas. In radix-2 the results are unchanged.
- R8: A sample that arrives together with in_frame is numbered n = 0, wherever the previous run stood. An in_frame pulse without in_valid makes the next valid sample n = 0.
- R9: Changes on in_half or in_inv between frame starts have no effect until the next in_frame.
- R10: A cycle with in_valid low advances nothing, drives out_valid to 0 and leaves the output lanes unchanged. The lanes also hold through fill cycles.
- R11: Results are exact two's-complement values on 18 bits for all 16-bit inputs, full-scale values included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_frame | input | 1 | Frame start: restarts numbering, latches size and direction |
| in_half | input | 1 | 1 = 128-point (dual radix-2), 0 = 256-point (radix-4) |
| in_inv | input | 1 | 1 = inverse transform |
| in_re | input | 16 | Input real part, signed |
| in_im | input | 16 | Input imaginary part, signed |
| out_valid | output | 1 | Output lanes updated this cycle |
| out_mode | output | 2 | Commutator routing mode (burst position) |
| out_re | output | 72 | Four 18-bit signed real results, lane 0 in the low bits |
| out_im | output | 72 | Four 18-bit signed imaginary results, lane 0 in the low bits |

## Verification
The bench targets several corner cases:
- Full-scale inputs. A design that grew the data too little would wrap to the wrong sign on these.
- A frame pulse in the middle of a run, and one with no valid sample. A design that ignored the pulse would pair samples from different runs.
- Toggling the size and inverse bits in mid-frame. A design without a latch would change kernel or rotation in mid-frame.
- Idle gaps. A design whose delay line moved on idle cycles would misalign the quarters.
- The 128-point rotation and the inverse lane swap. An error in either lands a correct value on the wrong lane.

Expected results come from a direct four-point transform with powers of j, not from the butterfly formulas.

// File: rtl/r24_pkg.sv
package r24_pkg;
  parameter int DW    = 16;
  parameter int OW    = DW + 2;
  parameter int LANES = 4;

  typedef struct packed {
    logic signed [DW-1:0] re;
    logic signed [DW-1:0] im;
  } smp_t;

  typedef struct packed {
    logic signed [OW-1:0] re;
    logic signed [OW-1:0] im;
  } wide_t;

  typedef wide_t [LANES-1:0] quad_t;

  function automatic wide_t widen(smp_t s);
    wide_t w;
    w.re = {{(OW-DW){s.re[DW-1]}}, s.re};
    w.im = {{(OW-DW){s.im[DW-1]}}, s.im};
    return w;
  endfunction

  function automatic wide_t cadd(wide_t x, wide_t y);
    wide_t r;
    r.re = x.re + y.re;
    r.im = x.im + y.im;
    return r;
  endfunction

  function automatic wide_t csub(wide_t x, wide_t y);
    wide_t r;
    r.re = x.re - y.re;
    r.im = x.im - y.im;
    return r;
  endfunction

  // times -j: (x + jy)(-j) = y - jx
  function automatic wide_t rot_mj(wide_t x);
    wide_t r;
    r.re = x.im;
    r.im = -x.re;
    return r;
  endfunction

  // times +j: (x + jy)(j) = -y + jx
  function automatic wide_t rot_pj(wide_t x);
    wide_t r;
    r.re = -x.im;
    r.im = x.re;
    return r;
  endfunction

  // radix-4 kernel; inverse direction exchanges the two j-rotated outputs
  function automatic quad_t kern_r4(wide_t a, wide_t b, wide_t c, wide_t d, logic inv);
    quad_t y;
    wide_t bq, dq, ac_s, ac_d;
    bq   = inv ? rot_pj(b) : rot_mj(b);
    dq   = inv ? rot_mj(d) : rot_pj(d);
    ac_s = cadd(a, c);
    ac_d = csub(a, c);
    y[0] = cadd(ac_s, cadd(b, d));
    y[1] = cadd(ac_d, cadd(bq, dq));
    y[2] = csub(ac_s, cadd(b, d));
    y[3] = csub(ac_d, cadd(bq, dq));
    return y;
  endfunction

  // two radix-2 kernels on the pairs (A,C) and (B,D)
  function automatic quad_t kern_r2(wide_t a, wide_t b, wide_t c, wide_t d);
    quad_t y;
    y[0] = cadd(a, c);
    y[1] = csub(a, c);
    y[2] = cadd(b, d);
    y[3] = csub(b, d);
    return y;
  endfunction
endpackage

// File: rtl/r24_sample_delay.sv
module r24_sample_delay
  import r24_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  smp_t din,
  output smp_t dout
);
  smp_t pipe [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else if (en) begin
      pipe[0] <= din;
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[DEPTH-1];
endmodule

// File: rtl/r24_butterfly.sv
module r24_butterfly
  import r24_pkg::*;
(
  input  smp_t  a,
  input  smp_t  b,
  input  smp_t  c,
  input  smp_t  d,
  input  logic  half,
  input  logic  inv,
  output quad_t y
);
  wide_t wa, wb, wc, wd;

  always_comb begin
    wa = widen(a);
    wb = widen(b);
    wc = widen(c);
    wd = widen(d);
    if (half) y = kern_r2(wa, wb, wc, wd);
    else      y = kern_r4(wa, wb, wc, wd, inv);
  end
endmodule

// File: rtl/r24_commutator.sv
module r24_commutator
  import r24_pkg::*;
#(
  localparam int MW = $clog2(LANES)
) (
  input  quad_t         y,
  input  logic          rotate,
  input  logic [MW-1:0] mode,
  output quad_t         z
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [MW-1:0] src;
    assign src  = rotate ? MW'(k) + mode : MW'(k);
    assign z[k] = y[src];
  end
endmodule

// File: rtl/r24_first_stage.sv
module r24_first_stage
  import r24_pkg::*;
#(
  parameter int SEG = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_frame,
  input  logic                  in_half,
  input  logic                  in_inv,
  input  logic [DW-1:0]         in_re,
  input  logic [DW-1:0]         in_im,
  output logic                  out_valid,
  output logic [1:0]            out_mode,
  output logic [LANES*OW-1:0]   out_re,
  output logic [LANES*OW-1:0]   out_im
);
  localparam int RUN  = 4 * SEG;
  localparam int FILL = 3 * SEG;
  localparam int IDXW = $clog2(RUN);
  localparam int MW   = $clog2(LANES);

  logic [IDXW-1:0] idx_q;
  logic            framed_q, half_q, inv_q;
  logic            bfly_fire, bfly_start;
  logic [MW-1:0]   mode_now;
  smp_t            tap [4];
  quad_t           bf_y, cm_z;

  // events brought out for the checker
  assign bfly_fire  = in_valid && framed_q && !in_frame && (idx_q >= IDXW'(FILL));
  assign mode_now   = MW'(idx_q - IDXW'(FILL));
  assign bfly_start = bfly_fire && (mode_now == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      framed_q <= 1'b0;
      half_q   <= 1'b0;
      inv_q    <= 1'b0;
    end else if (in_frame) begin
      idx_q    <= in_valid ? IDXW'(1) : '0;
      framed_q <= 1'b1;
      half_q   <= in_half;
      inv_q    <= in_inv;
    end else if (in_valid) begin
      idx_q <= (idx_q == IDXW'(RUN-1)) ? '0 : idx_q + 1'b1;
    end
  end

  // delay chain: segment outputs give quarters C, B, A behind the live D sample
  assign tap[0].re = in_re;
  assign tap[0].im = in_im;
  for (genvar g = 0; g < 3; g++) begin : g_seg
    r24_sample_delay #(.DEPTH(SEG)) u_seg (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (in_valid),
      .din  (tap[g]),
      .dout (tap[g+1])
    );
  end

  r24_butterfly u_bf (
    .a   (tap[3]),
    .b   (tap[2]),
    .c   (tap[1]),
    .d   (tap[0]),
    .half(half_q),
    .inv (inv_q),
    .y   (bf_y)
  );

  r24_commutator u_cm (
    .y     (bf_y),
    .rotate(half_q),
    .mode  (mode_now),
    .z     (cm_z)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mode  <= '0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= bfly_fire;
      if (bfly_fire) begin
        out_mode <= 2'(mode_now);
        for (int k = 0; k < LANES; k++) begin
          out_re[k*OW +: OW] <= cm_z[k].re;
          out_im[k*OW +: OW] <= cm_z[k].im;
        end
      end
    end
  end
endmodule

// File: rtl/r24_first_stage_chk.sv
module r24_first_stage_chk
  import r24_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_frame,
  input logic                out_valid,
  input logic [1:0]          out_mode,
  input logic [LANES*OW-1:0] out_re,
  input logic [LANES*OW-1:0] out_im,
  input logic                start_ev
);
  logic [3:0] c_pos;
  logic       c_framed;
  logic       c_window;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_pos    <= '0;
      c_framed <= 1'b0;
    end else if (in_frame) begin
      c_pos    <= in_valid ? 4'd1 : 4'd0;
      c_framed <= 1'b1;
    end else if (in_valid) begin
      c_pos <= c_pos + 4'd1;
    end
  end

  assign c_window = in_valid && c_framed && !in_frame && (c_pos >= 4'd12);

  assert_fill_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(c_window));

  assert_fill_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_window |=> out_valid);

  assert_frame_idx0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && in_valid) |=> !out_valid);

  assert_mode_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_mode == 2'd0) |-> $past(start_ev));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im)));
endmodule

bind r24_first_stage r24_first_stage_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_frame (in_frame),
  .out_valid(out_valid),
  .out_mode (out_mode),
  .out_re   (out_re),
  .out_im   (out_im),
  .start_ev (bfly_start)
);

// File: tb/r24_first_stage_bench.sv
`timescale 1ns/1ps
module r24_first_stage_bench;
  localparam int OW = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_frame = 1'b0, in_half = 1'b0, in_inv = 1'b0;
  logic [15:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic [1:0] out_mode;
  logic [4*OW-1:0] out_re, out_im;

  always #4 clk = ~clk;

  r24_first_stage u_r24_first_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame(in_frame),
    .in_half(in_half), .in_inv(in_inv), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_mode(out_mode), .out_re(out_re), .out_im(out_im)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string req = "R1";

  // bench model state
  int m_idx = 0;
  bit m_framed = 0, m_half = 0, m_inv = 0;
  int bre [16], bim [16];
  int last_re [4], last_im [4];
  int last_mode = 0;

  function automatic int lane_re(int k);
    return int'($signed(out_re[k*OW +: OW]));
  endfunction
  function automatic int lane_im(int k);
    return int'($signed(out_im[k*OW +: OW]));
  endfunction

  // multiply (re,im) by j^p
  function automatic void jpow(input int re, input int im, input int p, output int ore, output int oim);
    case (p % 4)
      0: begin ore = re;  oim = im;  end
      1: begin ore = -im; oim = re;  end
      2: begin ore = -re; oim = -im; end
      default: begin ore = im; oim = -re; end
    endcase
  endfunction

  task automatic check(string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit fr, int re, int im);
    bit fire = 0;
    int i = 0;
    int xr [4], xi [4], yr [4], yi [4];
    if (fr) begin m_idx = 0; m_framed = 1; m_half = in_half; m_inv = in_inv; end
    if (v) begin
      bre[m_idx] = re; bim[m_idx] = im;
      if (m_framed && m_idx >= 12) begin fire = 1; i = m_idx - 12; end
      m_idx = (m_idx + 1) % 16;
    end
    in_valid = v; in_frame = fr; in_re = 16'(re); in_im = 16'(im);
    @(negedge clk);
    in_frame = 0; in_valid = 0;
    check("out_valid", int'(out_valid), int'(fire));
    if (fire) begin
      for (int n = 0; n < 4; n++) begin xr[n] = bre[4*n+i]; xi[n] = bim[4*n+i]; end
      if (m_half) begin
        yr[0] = xr[0] + xr[2]; yi[0] = xi[0] + xi[2];
        yr[1] = xr[0] - xr[2]; yi[1] = xi[0] - xi[2];
        yr[2] = xr[1] + xr[3]; yi[2] = xi[1] + xi[3];
        yr[3] = xr[1] - xr[3]; yi[3] = xi[1] - xi[3];
      end else begin
        for (int k = 0; k < 4; k++) begin
          yr[k] = 0; yi[k] = 0;
          for (int n = 0; n < 4; n++) begin
            int tr, ti;
            jpow(xr[n], xi[n], m_inv ? (n*k) : (3*n*k), tr, ti);
            yr[k] += tr; yi[k] += ti;
          end
        end
      end
      for (int k = 0; k < 4; k++) begin
        int s;
        s = m_half ? ((k + i) % 4) : k;
        last_re[k] = yr[s]; last_im[k] = yi[s];
      end
      last_mode = i;
    end
    // R6 mode, R4/R5/R7/R11 values; R10 hold when not firing
    check("out_mode", int'(out_mode), last_mode);
    for (int k = 0; k < 4; k++) begin
      check($sformatf("lane%0d re", k), lane_re(k), last_re[k]);
      check($sformatf("lane%0d im", k), lane_im(k), last_im[k]);
    end
  endtask

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  task automatic burst(int cnt, bit first_frame, int idle_pct);
    for (int s = 0; s < cnt; s++) begin
      if (idle_pct > 0 && ($urandom % 100) < idle_pct) step(0, 0, rnd16(), rnd16());
      step(1, first_frame && s == 0, rnd16(), rnd16());
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 4; k++) begin last_re[k] = 0; last_im[k] = 0; end
    repeat (3) @(negedge clk);
    // R1: outputs quiet during and after reset
    req = "R1";
    check("out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("out_valid", int'(out_valid), 0);
    check("out_mode", int'(out_mode), 0);
    check("lane0 re", lane_re(0), 0);
    check("lane3 im", lane_im(3), 0);

    req = "R2";   // no frame yet
    burst(20, 0, 0);

    req = "R4";   // radix-4 forward, also R3 alignment
    in_half = 0; in_inv = 0;
    burst(48, 1, 0);

    req = "R11";  // full scale
    for (int s = 0; s < 32; s++) begin
      int vr, vi;
      vr = ($urandom % 2) ? 32767 : -32768;
      vi = ($urandom % 2) ? 32767 : -32768;
      if (s < 16) begin vr = -32768; vi = -32768; end
      step(1, s == 0, vr, vi);
    end

    req = "R5";   // dual radix-2 with rotation R6
    in_half = 1;
    burst(48, 1, 0);

    req = "R7";   // inverse, both sizes
    in_half = 0; in_inv = 1;
    burst(32, 1, 0);
    in_half = 1;
    burst(32, 1, 0);

    req = "R9";   // config toggled mid-frame
    in_half = 0; in_inv = 0;
    burst(6, 1, 0);
    in_half = 1; in_inv = 1;
    burst(26, 0, 0);

    req = "R8";   // restart mid-run, and frame without valid
    in_half = 0; in_inv = 1;
    burst(7, 1, 0);
    burst(20, 1, 0);
    in_half = 1; in_inv = 0;
    burst(5, 1, 0);
    step(0, 1, 0, 0);
    burst(20, 0, 0);

    req = "R10";  // idle gaps
    in_half = 1; in_inv = 1;
    burst(64, 1, 35);
    in_half = 0; in_inv = 0;
    burst(64, 1, 35);

    req = "R3";   // long random mix
    for (int r = 0; r < 20; r++) begin
      in_half = $urandom % 2; in_inv = $urandom % 2;
      burst(16 + ($urandom % 40), 1, 20);
    end
    finish_run();
  end
endmodule